// File: doc/BRIEF.md
# Priority-Programmable Interrupt Controller

This block gathers interrupt events from 41 fixed sources. Fifteen are external request lines, one is a non-maskable input, and the rest are on-chip sources: timers, the real-time clock, two serial ports, the watchdog, memory refresh, DMA, general-purpose I/O and a debug port. Each event arrives as a one-cycle raise pulse and is withdrawn by a one-cycle clear pulse. Every source has a priority. The external lines and the non-maskable input have fixed priorities. Each on-chip source takes its priority from a 4-bit field in one of three 16-bit priority registers, and one field serves a whole group of related sources. Software writes and reads these registers over a simple bus.

A pending-set stage holds the raised sources and picks the top one. A two-state request machine then compares that source with the CPU's 4-bit mask level and its block bit. It drives a registered interrupt request and the 12-bit exception code of the winning source.

The request machine has two states. In `REQ_IDLE` the request is low. In `REQ_ACTIVE` the request is high. The *assert* transition goes from `REQ_IDLE` to `REQ_ACTIVE` when the request condition holds. The *withdraw* transition goes from `REQ_ACTIVE` to `REQ_IDLE` when the condition fails. Otherwise the machine holds its state.

Top module: `intc_top`

## Requirements
- R1: Only address bits 11:0 are decoded. Offset 0x000 is a control register, 0x004 is priority register A, 0x008 is priority register B, and 0x00C is priority register C. A write stores all 16 bits, and a read returns the last value written there, including the reserved bits and the control register. Any other offset reads as 0 and ignores writes. The control register has no other effect.
- R2: After reset, all four registers read 0, the request is low and the code is 0. External request n (sources 0 to 14) has priority 15−n, the non-maskable input (source 15) has priority 16, and every other source has priority 0.
- R3: Source indices and their priority fields are as follows. Register A: bits 15:12 set timer 0 (source 23), 11:8 set timer 1 (24), 7:4 set timer 2 and input capture (25, 26), and 3:0 set the alarm, periodic and carry clock sources (27 to 29). Register B: bits 15:12 set the watchdog (38), 11:8 set refresh compare and overflow (39, 40), 7:4 set the four serial sources (30 to 33), and 3:0 are unused. Register C: bits 15:12 set I/O (17), 11:8 set DMA end 0 to 3 and DMA address error (18 to 22), 7:4 set the four FIFO serial sources (34 to 37), and 3:0 set debug (16).
- R4: A raise pulse for a source whose priority is currently 0 is ignored. The source does not become pending, even if its priority is raised later.
- R5: A raise pulse marks a source pending, and repeating it has no further effect. One clear pulse removes the source. When raise and clear arrive in the same cycle, clear wins.
- R6: The top pending source is the one with the highest priority. On a tie, the lowest source index wins. A pending source whose priority is 0 never wins.
- R7: The exception code is 0 when no source can win. Otherwise it is the winner's code, which does not depend on the mask or the block bit. The codes are: source n<15 gives 0x200+0x20·n; 15 gives 0x1C0; 16 gives 0x600; 17 gives 0x620; 18 to 22 give 0x640+0x20·(n−18); 23 to 33 give 0x400+0x20·(n−23); 34 to 37 give 0x700+0x20·(n−34); 38 to 40 give 0x560+0x20·(n−38).
- R8: The request is high only if a winner exists and the 4-bit mask level is strictly lower than the winner's priority.
- R9: The request is low whenever the block bit was high in the previous cycle.
- R10: The request and the code are registered. They follow a change of mask, block bit, priority or pending set one clock later. A raise pulse therefore shows on the outputs two clocks after the cycle in which it arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_i | input | 41 | One-cycle raise pulse per source |
| clear_i | input | 41 | One-cycle clear pulse per source |
| cpu_mask_i | input | 4 | CPU interrupt mask level |
| cpu_block_i | input | 1 | CPU block bit, high blocks all requests |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 16 | Register address, low 12 bits decoded |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data, combinational from the address |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| exc_code_o | output | 12 | Exception code of the top pending source |

## Verification
The assertions assume that raise and clear are single-cycle pulses, sampled at the clock. They also assume that the mask and block inputs are stable between edges. The bench drives every input just after the falling edge, so each input holds a whole cycle. The assertions also assume that nothing but the bus changes the priorities. The bench reprograms the registers only while no source is pending, except in the test of the priority-0 case, which relies on an empty pending set. The pair sweep raises two sources in one pulse and clears them together, so the pending set never carries over into the next case.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int N_SRC    = 41;
    localparam int N_EXT    = 15;
    localparam int SRC_NMI  = 15;
    localparam int FIELD_W  = 4;
    localparam int PRI_W    = FIELD_W + 1;
    localparam int MASK_W   = 4;
    localparam int CODE_W   = 12;
    localparam int REG_W    = 16;
    localparam int DEC_W    = 12;
    localparam int IDX_W    = $clog2(N_SRC);
    localparam int CODE_STEP = 'h20;

    localparam logic [DEC_W-1:0] OFS_CTRL = 12'h000;
    localparam logic [DEC_W-1:0] OFS_PRA  = 12'h004;
    localparam logic [DEC_W-1:0] OFS_PRB  = 12'h008;
    localparam logic [DEC_W-1:0] OFS_PRC  = 12'h00C;

    typedef logic [PRI_W-1:0] pri_t;
    typedef enum logic {REQ_IDLE, REQ_ACTIVE} req_state_t;

    // Exception code of a source: group base plus a fixed step per member.
    function automatic logic [CODE_W-1:0] src_code(input int s);
        int base;
        int idx;
        if (s < N_EXT) begin
            base = 'h200; idx = s;
        end else if (s == SRC_NMI) begin
            base = 'h1C0; idx = 0;
        end else if (s <= 17) begin
            base = 'h600; idx = s - 16;
        end else if (s <= 22) begin
            base = 'h640; idx = s - 18;
        end else if (s <= 33) begin
            base = 'h400; idx = s - 23;
        end else if (s <= 37) begin
            base = 'h700; idx = s - 34;
        end else begin
            base = 'h560; idx = s - 38;
        end
        return CODE_W'(base + CODE_STEP * idx);
    endfunction
endpackage

// File: rtl/intc_prio_regs.sv
module intc_prio_regs
    import intc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [REG_W-1:0]             wdata,
    output logic [REG_W-1:0]             rdata,
    output logic [N_SRC-1:0][PRI_W-1:0]  prio
);
    logic [REG_W-1:0] ctrl_q, pra_q, prb_q, prc_q;
    logic [DEC_W-1:0] ofs;
    logic             unused_addr_hi;

    assign ofs            = addr[DEC_W-1:0];
    assign unused_addr_hi = ^addr[ADDR_W-1:DEC_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pra_q  <= '0;
            prb_q  <= '0;
            prc_q  <= '0;
        end else if (wr) begin
            unique case (ofs)
                OFS_CTRL: ctrl_q <= wdata;
                OFS_PRA:  pra_q  <= wdata;
                OFS_PRB:  prb_q  <= wdata;
                OFS_PRC:  prc_q  <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_CTRL: rdata = ctrl_q;
            OFS_PRA:  rdata = pra_q;
            OFS_PRB:  rdata = prb_q;
            OFS_PRC:  rdata = prc_q;
            default:  rdata = '0;
        endcase
    end

    // Per-source priority: fixed for external and non-maskable, field lookup otherwise.
    always_comb begin
        for (int s = 0; s < N_SRC; s++) begin
            logic [FIELD_W-1:0] f;
            f = '0;
            if      (s == 16)             f = prc_q[3:0];
            else if (s == 17)             f = prc_q[15:12];
            else if (s >= 18 && s <= 22)  f = prc_q[11:8];
            else if (s == 23)             f = pra_q[15:12];
            else if (s == 24)             f = pra_q[11:8];
            else if (s >= 25 && s <= 26)  f = pra_q[7:4];
            else if (s >= 27 && s <= 29)  f = pra_q[3:0];
            else if (s >= 30 && s <= 33)  f = prb_q[7:4];
            else if (s >= 34 && s <= 37)  f = prc_q[7:4];
            else if (s == 38)             f = prb_q[15:12];
            else if (s >= 39)             f = prb_q[11:8];
            if (s < N_EXT)
                prio[s] = PRI_W'(N_EXT - s);
            else if (s == SRC_NMI)
                prio[s] = PRI_W'(1 << FIELD_W);
            else
                prio[s] = {1'b0, f};
        end
    end
endmodule

// File: rtl/intc_pending_queue.sv
module intc_pending_queue
    import intc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_SRC-1:0]             raise,
    input  logic [N_SRC-1:0]             clear,
    input  logic [N_SRC-1:0][PRI_W-1:0]  prio,
    output logic [N_SRC-1:0]             pend,
    output logic                         win_valid,
    output logic [IDX_W-1:0]             win_idx,
    output logic [PRI_W-1:0]             win_prio
);
    logic [N_SRC-1:0] accept;

    always_comb begin
        for (int s = 0; s < N_SRC; s++)
            accept[s] = raise[s] && (prio[s] != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend | accept) & ~clear;
    end

    // Strictly-greater scan from index 0 keeps the lowest index on a tie.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (pend[s] && prio[s] > win_prio) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(s);
                win_prio  = prio[s];
            end
        end
    end
endmodule

// File: rtl/intc_req_fsm.sv
module intc_req_fsm
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_valid,
    input  logic [IDX_W-1:0]   win_idx,
    input  logic [PRI_W-1:0]   win_prio,
    input  logic [MASK_W-1:0]  cpu_mask,
    input  logic               cpu_block,
    output logic               irq_req,
    output logic [CODE_W-1:0]  exc_code
);
    req_state_t state_q, state_d;
    logic       eligible;

    assign eligible = win_valid && !cpu_block &&
                      (PRI_W'(cpu_mask) < win_prio);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:   if (eligible)  state_d = REQ_ACTIVE;
            REQ_ACTIVE: if (!eligible) state_d = REQ_IDLE;
            default:    state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         exc_code <= '0;
        else if (win_valid) exc_code <= src_code(int'(win_idx));
        else                exc_code <= '0;
    end

    assign irq_req = (state_q == REQ_ACTIVE);
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    raise_i,
    input  logic [N_SRC-1:0]    clear_i,
    input  logic [MASK_W-1:0]   cpu_mask_i,
    input  logic                cpu_block_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [REG_W-1:0]    bus_wdata_i,
    output logic [REG_W-1:0]    bus_rdata_o,
    output logic                irq_req_o,
    output logic [CODE_W-1:0]   exc_code_o
);
    logic [N_SRC-1:0][PRI_W-1:0] prio_w;
    logic [N_SRC-1:0]            pend_w;
    logic                        win_valid_w;
    logic [IDX_W-1:0]            win_idx_w;
    logic [PRI_W-1:0]            win_prio_w;

    intc_prio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr_i),
        .addr  (bus_addr_i),
        .wdata (bus_wdata_i),
        .rdata (bus_rdata_o),
        .prio  (prio_w)
    );

    intc_pending_queue u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .raise     (raise_i),
        .clear     (clear_i),
        .prio      (prio_w),
        .pend      (pend_w),
        .win_valid (win_valid_w),
        .win_idx   (win_idx_w),
        .win_prio  (win_prio_w)
    );

    intc_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid_w),
        .win_idx   (win_idx_w),
        .win_prio  (win_prio_w),
        .cpu_mask  (cpu_mask_i),
        .cpu_block (cpu_block_i),
        .irq_req   (irq_req_o),
        .exc_code  (exc_code_o)
    );
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_SRC-1:0]             raise,
    input  logic [N_SRC-1:0]             clear,
    input  logic [MASK_W-1:0]            cpu_mask,
    input  logic                         cpu_block,
    input  logic [N_SRC-1:0]             pend,
    input  logic [N_SRC-1:0][PRI_W-1:0]  prio,
    input  logic                         win_valid,
    input  logic [IDX_W-1:0]             win_idx,
    input  logic [PRI_W-1:0]             win_prio,
    input  logic                         irq_req,
    input  logic [CODE_W-1:0]            exc_code
);
    logic             past_ok;
    logic [N_SRC-1:0] nz;

    always_comb begin
        for (int s = 0; s < N_SRC; s++) nz[s] = (prio[s] != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r4_zero_prio_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((pend & ~$past(pend) & ~($past(raise) & $past(nz))) == '0));

    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((pend & $past(clear)) == '0));

    a_r6_winner_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (pend[win_idx] && prio[win_idx] == win_prio));

    a_r8_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && irq_req) |-> (PRI_W'($past(cpu_mask)) < $past(win_prio)));

    a_r9_block_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && irq_req) |-> !$past(cpu_block));

    a_r7_code_with_request: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (exc_code != '0));
endmodule

bind intc_top intc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise     (raise_i),
    .clear     (clear_i),
    .cpu_mask  (cpu_mask_i),
    .cpu_block (cpu_block_i),
    .pend      (pend_w),
    .prio      (prio_w),
    .win_valid (win_valid_w),
    .win_idx   (win_idx_w),
    .win_prio  (win_prio_w),
    .irq_req   (irq_req_o),
    .exc_code  (exc_code_o)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 41;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] raise_i = '0;
    logic [NS-1:0] clear_i = '0;
    logic [3:0]    cpu_mask_i = '0;
    logic          cpu_block_i = 1'b0;
    logic          bus_wr_i = 1'b0;
    logic [15:0]   bus_addr_i = '0;
    logic [15:0]   bus_wdata_i = '0;
    logic [15:0]   bus_rdata_o;
    logic          irq_req_o;
    logic [11:0]   exc_code_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [15:0] ra = '0, rb = '0, rc = '0;

    intc_top dut (
        .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .clear_i(clear_i),
        .cpu_mask_i(cpu_mask_i), .cpu_block_i(cpu_block_i),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_req_o(irq_req_o), .exc_code_o(exc_code_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int exp_prio(input int s);
        if (s < 15)  return 15 - s;
        if (s == 15) return 16;
        if (s == 16) return int'(rc[3:0]);
        if (s == 17) return int'(rc[15:12]);
        if (s <= 22) return int'(rc[11:8]);
        if (s == 23) return int'(ra[15:12]);
        if (s == 24) return int'(ra[11:8]);
        if (s <= 26) return int'(ra[7:4]);
        if (s <= 29) return int'(ra[3:0]);
        if (s <= 33) return int'(rb[7:4]);
        if (s <= 37) return int'(rc[7:4]);
        if (s == 38) return int'(rb[15:12]);
        return int'(rb[11:8]);
    endfunction

    function automatic int exp_code(input int s);
        if (s < 15)  return 'h200 + 32 * s;
        if (s == 15) return 'h1C0;
        if (s == 16) return 'h600;
        if (s == 17) return 'h620;
        if (s <= 22) return 'h640 + 32 * (s - 18);
        if (s <= 33) return 'h400 + 32 * (s - 23);
        if (s <= 37) return 'h700 + 32 * (s - 34);
        return 'h560 + 32 * (s - 38);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        tick();
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input string req, input logic [15:0] a, input int exp);
        bus_addr_i = a;
        #1;
        chk(req, int'(bus_rdata_o), exp);
    endtask

    task automatic pulse(input logic [NS-1:0] r, input logic [NS-1:0] c);
        raise_i = r; clear_i = c;
        tick();
        raise_i = '0; clear_i = '0;
    endtask

    task automatic clear_all();
        pulse('0, '1);
        tick();
    endtask

    task automatic single_sweep(input string req);
        for (int s = 0; s < NS; s++) begin
            int p;
            p = exp_prio(s);
            pulse(NS'(1) << s, '0);
            tick();
            chk({req, " irq"}, int'(irq_req_o), (p > 0) ? 1 : 0);
            chk({req, " code"}, int'(exc_code_o), (p > 0) ? exp_code(s) : 0);
            pulse('0, NS'(1) << s);
            tick();
            chk("R5 clear", int'(irq_req_o), 0);
        end
    endtask

    initial begin
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        tick();

        // R2 reset state
        chk("R2 irq", int'(irq_req_o), 0);
        chk("R2 code", int'(exc_code_o), 0);
        rd("R2 ctrl", 16'h000, 0);
        rd("R2 pra", 16'h004, 0);
        rd("R2 prb", 16'h008, 0);
        rd("R2 prc", 16'h00C, 0);

        // R2 / R7: default priorities, only sources 0..15 can request
        single_sweep("R2 default");

        // R1: aliasing through upper address bits, readback, reserved bits
        ra = 16'h9ABC; rb = 16'h5675; rc = 16'h3E21;
        wr(16'hF004, ra);
        wr(16'h3008, rb);
        wr(16'h000C, rc);
        wr(16'hA000, 16'hBEEF);
        wr(16'h0010, 16'h1234);
        rd("R1 pra", 16'h0004, int'(ra));
        rd("R1 prb reserved kept", 16'h0008, int'(rb));
        rd("R1 prc", 16'h700C, int'(rc));
        rd("R1 ctrl", 16'h0000, 'hBEEF);
        rd("R1 unmapped", 16'h0010, 0);
        tick();
        chk("R1 ctrl no effect", int'(irq_req_o), 0);

        // R3 / R7: programmed group priorities
        single_sweep("R3 R7 programmed");

        // R6: every pair of sources, mask 0
        for (int s = 0; s < NS; s++) begin
            for (int t = s + 1; t < NS; t++) begin
                int w;
                w = (exp_prio(s) >= exp_prio(t)) ? s : t;
                pulse((NS'(1) << s) | (NS'(1) << t), '0);
                tick();
                chk("R6 pair code", int'(exc_code_o), exp_code(w));
                pulse('0, (NS'(1) << s) | (NS'(1) << t));
            end
        end
        tick();
        chk("R6 pairs cleared", int'(irq_req_o), 0);

        // R8: mask sweep against source 5 (priority 10)
        pulse(NS'(1) << 5, '0);
        for (int m = 0; m < 16; m++) begin
            cpu_mask_i = 4'(m);
            tick();
            chk("R8 mask", int'(irq_req_o), (m < 10) ? 1 : 0);
            chk("R8 code", int'(exc_code_o), 'h2A0);
        end
        pulse(NS'(1) << 15, '0);
        tick();
        chk("R8 nmi above mask 15", int'(irq_req_o), 1);
        chk("R8 nmi code", int'(exc_code_o), 'h1C0);
        cpu_mask_i = '0;
        clear_all();

        // R9: block bit
        pulse(NS'(1) << 0, '0);
        cpu_block_i = 1'b1;
        tick();
        chk("R9 blocked", int'(irq_req_o), 0);
        chk("R9 code kept", int'(exc_code_o), 'h200);
        cpu_block_i = 1'b0;
        tick();
        chk("R9 unblocked", int'(irq_req_o), 1);
        clear_all();

        // R10: two clocks from raise to outputs
        raise_i = NS'(1) << 3;
        tick();
        raise_i = '0;
        chk("R10 not yet", int'(irq_req_o), 0);
        tick();
        chk("R10 after two", int'(irq_req_o), 1);
        chk("R10 code", int'(exc_code_o), 'h260);
        clear_all();

        // R4: raise at priority 0 is dropped
        rc = 16'h0000;
        wr(16'h000C, rc);
        pulse(NS'(1) << 17, '0);
        tick();
        chk("R4 masked raise", int'(irq_req_o), 0);
        rc = 16'hF000;
        wr(16'h000C, rc);
        tick();
        chk("R4 not pended", int'(irq_req_o), 0);
        chk("R4 code idle", int'(exc_code_o), 0);
        pulse(NS'(1) << 17, '0);
        tick();
        chk("R4 now accepted", int'(exc_code_o), 'h620);
        clear_all();

        // R5: duplicate raise, single clear; simultaneous raise and clear
        pulse(NS'(1) << 7, '0);
        pulse(NS'(1) << 7, '0);
        pulse('0, NS'(1) << 7);
        tick();
        chk("R5 dup cleared", int'(irq_req_o), 0);
        pulse(NS'(1) << 8, NS'(1) << 8);
        tick();
        chk("R5 clear wins", int'(irq_req_o), 0);
        chk("R5 clear wins code", int'(exc_code_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule